// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

A bank of up to 32 general-purpose pins behind a small memory-mapped register interface. Each pin works either as a plain I/O pin (driven from an output latch when its direction bit is set, sampled otherwise) or as an interrupt source. An interrupt source senses either a level or an edge. Its polarity is selectable, and in edge mode it can fire on both edges.

Every pad value passes through a two-flop synchroniser before any logic sees it. Interrupt events collect in a pending register. A per-pin enable, set and cleared through two write-1 registers, gates the pending bits onto a single combined interrupt line. Software reads the pending register, clears serviced edge events by writing 1s, and unmasks pins by writing 1s to a dedicated unmask address.

The bus is a simple APB-like access. A write takes effect at the clock edge where `bus_sel`, `bus_enable` and `bus_write` are all high. Read data is combinational from `bus_addr` while `bus_sel` is high. Register byte offsets use `bus_addr[5:2]`.

Top module: `gpio_irq_bank`

## Requirements
- R1: After a clock edge with `rst_n` low, every pin is in general I/O mode as an input, so `pad_oe` is 0. The output latch is 0, every enable bit is 0 (masked), nothing is pending and `irq_out` is 0.
- R2: The mode register (0x00, 1 = interrupt input) and the direction register (0x04, 1 = output) together set `pad_oe[i]`, which is high exactly when mode is 0 and direction is 1. `pad_out` always shows the output latch (0x08). The pin data read (0x0C) returns the latch bit for pins with `pad_oe` high and the synchronised input bit for all other pins.
- R3: The synchronised input register (0x28, read only) shows `pad_in` after two clock edges.
- R4: In level mode, pending follows the synchronised input XOR the polarity bit one edge later. The polarity bit is at 0x10, 1 = active low or falling edge. Level mode is edge-select 0 in register 0x14. A clear write does not remove a level that is still active.
- R5: In edge mode (0x14 bit 1) with both-edges 0, a pin with polarity 0 sets pending on a rising synchronised edge and a pin with polarity 1 on a falling one. The bit stays set until it is cleared.
- R6: With the both-edges bit set (0x18), an edge-mode pin sets pending on rising and on falling edges, whatever its polarity bit.
- R7: Writing 1s to the pending register (0x1C) clears those latched edge events. Bits written as 0 are unchanged.
- R8: Writing 1s to 0x20 masks those pins, and writing 1s to 0x24 unmasks them. Zero bits leave the enable unchanged. 0x20 reads the enable bits and 0x24 reads 0. `irq_out` is high exactly while pending AND enable is nonzero.
- R9: An edge detected in the same cycle as a clear write to that bit leaves the pending bit set.
- R10: A pin in general I/O mode has its pending bit at 0 from the edge after it enters that mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bank selected |
| bus_enable | input | 1 | Access phase |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, zero when not selected |
| pad_in | input | NPINS | Asynchronous pad inputs |
| pad_out | output | NPINS | Output latch to the pads |
| pad_oe | output | NPINS | Per-pin output enable |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A pad change reaches the synchronised-input and pin-data reads after two edges. It reaches the pending register and `irq_out` one edge after that. A register write changes state and reads at the edge where it is sampled. The bench's behavioural model advances its own two-stage sample queue and pending bits once per rising edge from the inputs held over that edge. Outputs and read data are compared at the falling edge that follows, so every result is judged in the cycle it is due. A sweep of clear writes at shifting offsets after a pad edge puts one clear exactly on the detecting edge.

// File: rtl/gpio_bank_pkg.sv
// Package: register indices shared by the bank and its checker.
// Assumes word-aligned byte addresses; index = address bits [5:2].
package gpio_bank_pkg;
    typedef enum logic [3:0] {
        IDX_MODE   = 4'd0,
        IDX_DIR    = 4'd1,
        IDX_OUT    = 4'd2,
        IDX_PIN    = 4'd3,
        IDX_POL    = 4'd4,
        IDX_EDGE   = 4'd5,
        IDX_BOTH   = 4'd6,
        IDX_PEND   = 4'd7,
        IDX_MASK   = 4'd8,
        IDX_UNMASK = 4'd9,
        IDX_SYNC   = 4'd10
    } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
// gpio_sync: multi-stage synchroniser for asynchronous pad inputs.
// Assumes STAGES >= 1; all stages reset to 0.
module gpio_sync #(
    parameter int NPINS  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] smp
);
    logic [NPINS-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first stage samples the raw pads
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= '0;
                else        chain[0] <= pad_in;
            end
        end else begin : g_next
            // later stages shift the sample along
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign smp = chain[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
// gpio_regfile: per-pin configuration, output latch and interrupt enables.
// Assumes one write per cycle decoded from a register index.
module gpio_regfile
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_idx_e         idx,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] isel,
    output logic [NPINS-1:0] dir,
    output logic [NPINS-1:0] outd,
    output logic [NPINS-1:0] pol,
    output logic [NPINS-1:0] edge_sel,
    output logic [NPINS-1:0] both,
    output logic [NPINS-1:0] en,
    output logic [NPINS-1:0] pend_clr
);
    // configuration and enable registers updated by bus writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isel     <= '0;
            dir      <= '0;
            outd     <= '0;
            pol      <= '0;
            edge_sel <= '0;
            both     <= '0;
            en       <= '0;
        end else if (wr_en) begin
            case (idx)
                IDX_MODE:   isel     <= wdata;
                IDX_DIR:    dir      <= wdata;
                IDX_OUT:    outd     <= wdata;
                IDX_POL:    pol      <= wdata;
                IDX_EDGE:   edge_sel <= wdata;
                IDX_BOTH:   both     <= wdata;
                IDX_MASK:   en       <= en & ~wdata;
                IDX_UNMASK: en       <= en | wdata;
                default:    ;
            endcase
        end
    end

    // clear strobe for the pending latches
    always_comb begin
        pend_clr = (wr_en && idx == IDX_PEND) ? wdata : '0;
    end
endmodule

// File: rtl/gpio_trigger.sv
// gpio_trigger: per-pin level/edge detection and pending latches.
// Assumes smp is already synchronised; edge = change between consecutive samples.
module gpio_trigger #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] smp,
    input  logic [NPINS-1:0] isel,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] edge_sel,
    input  logic [NPINS-1:0] both,
    input  logic [NPINS-1:0] pend_clr,
    output logic [NPINS-1:0] pend
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic prev_q;
        logic pend_q;
        logic rise;
        logic fall;
        logic hit;

        // previous sample for edge comparison
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= smp[i];
        end

        // edge event selection from polarity and both-edges bits
        always_comb begin
            rise = smp[i] & ~prev_q;
            fall = ~smp[i] & prev_q;
            if (both[i])     hit = rise | fall;
            else if (pol[i]) hit = fall;
            else             hit = rise;
        end

        // pending latch: level follows, edge sticks, new edge beats clear
        always_ff @(posedge clk) begin
            if (!rst_n)            pend_q <= 1'b0;
            else if (!isel[i])     pend_q <= 1'b0;
            else if (!edge_sel[i]) pend_q <= smp[i] ^ pol[i];
            else                   pend_q <= (pend_q & ~pend_clr[i]) | hit;
        end

        assign pend[i] = pend_q;
    end
endmodule

// File: rtl/gpio_irq_bank.sv
// gpio_irq_bank: 32-pin GPIO bank with interrupt sensing and combined irq.
// Assumes NPINS <= DATA_W and ADDR_W >= 6; reads are combinational.
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_enable,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq_out
);
    logic             wr_en;
    reg_idx_e         reg_idx;
    logic [NPINS-1:0] wdata_p;
    logic [NPINS-1:0] isel, dir, outd, pol, edge_sel, both, en, pend_clr;
    logic [NPINS-1:0] smp, pend, pin_val;
    logic [NPINS-1:0] rd_val;
    logic [1:0]       unused_addr_lsb;

    // bus decode
    always_comb begin
        wr_en   = bus_sel & bus_enable & bus_write;
        reg_idx = reg_idx_e'(bus_addr[5:2]);
        wdata_p = bus_wdata[NPINS-1:0];
    end
    assign unused_addr_lsb = bus_addr[1:0];

    gpio_regfile #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(reg_idx), .wdata(wdata_p),
        .isel(isel), .dir(dir), .outd(outd), .pol(pol), .edge_sel(edge_sel),
        .both(both), .en(en), .pend_clr(pend_clr)
    );

    gpio_sync #(.NPINS(NPINS), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .smp(smp)
    );

    gpio_trigger #(.NPINS(NPINS)) u_trig (
        .clk(clk), .rst_n(rst_n), .smp(smp), .isel(isel), .pol(pol),
        .edge_sel(edge_sel), .both(both), .pend_clr(pend_clr), .pend(pend)
    );

    // pad drive and pin data view
    always_comb begin
        pad_oe  = ~isel & dir;
        pad_out = outd;
        pin_val = (pad_oe & outd) | (~pad_oe & smp);
        irq_out = |(pend & en);
    end

    // read mux
    always_comb begin
        case (reg_idx)
            IDX_MODE: rd_val = isel;
            IDX_DIR:  rd_val = dir;
            IDX_OUT:  rd_val = outd;
            IDX_PIN:  rd_val = pin_val;
            IDX_POL:  rd_val = pol;
            IDX_EDGE: rd_val = edge_sel;
            IDX_BOTH: rd_val = both;
            IDX_PEND: rd_val = pend;
            IDX_MASK: rd_val = en;
            IDX_SYNC: rd_val = smp;
            default:  rd_val = '0;
        endcase
        bus_rdata = bus_sel ? DATA_W'(rd_val) : '0;
    end
endmodule

// File: rtl/gpio_bank_checker.sv
// gpio_bank_checker: temporal properties of gpio_irq_bank, attached by bind.
// Assumes it observes the top's internal configuration and pending state.
module gpio_bank_checker
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [3:0]       idx,
    input logic [NPINS-1:0] wdata,
    input logic [NPINS-1:0] isel,
    input logic [NPINS-1:0] edge_sel,
    input logic [NPINS-1:0] pol,
    input logic [NPINS-1:0] smp,
    input logic [NPINS-1:0] pend,
    input logic [NPINS-1:0] en,
    input logic [NPINS-1:0] pad_oe,
    input logic             irq_out
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (pend == '0 && en == '0 && pad_oe == '0 && !irq_out));

    assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(isel & ~edge_sel)) ==
                  $past((smp ^ pol) & isel & ~edge_sel)));

    assert_edge_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((pend & $past(pend & isel & edge_sel)) ==
                    $past(pend & isel & edge_sel)));

    assert_unmask_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == 4'(IDX_UNMASK)) |=> ((en & $past(wdata)) == $past(wdata)));

    assert_mask_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == 4'(IDX_MASK)) |=> ((en & $past(wdata)) == '0));

    assert_gio_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(isel)) == '0));
endmodule

bind gpio_irq_bank gpio_bank_checker #(.NPINS(NPINS)) u_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(bus_addr[5:2]), .wdata(wdata_p),
    .isel(isel), .edge_sel(edge_sel), .pol(pol), .smp(smp), .pend(pend),
    .en(en), .pad_oe(pad_oe), .irq_out(irq_out)
);

// File: tb/tb_gpio_irq_bank.sv
// Bench: behavioural reference model advanced each rising edge, compared each falling edge.
module tb_gpio_irq_bank;
    localparam logic [5:0] A_MODE = 6'h00, A_DIR = 6'h04, A_OUT = 6'h08, A_PIN = 6'h0C,
                           A_POL = 6'h10, A_EDGE = 6'h14, A_BOTH = 6'h18, A_PEND = 6'h1C,
                           A_MASK = 6'h20, A_UNMASK = 6'h24, A_SYNC = 6'h28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_enable = 1'b0, bus_write = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq_out;

    int vectors = 0;
    int misses  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_enable(bus_enable),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .irq_out(irq_out)
    );

    // reference state
    logic [31:0] m_mode, m_dir, m_out, m_pol, m_edge, m_both, m_en, m_pend;
    logic [31:0] m_s1, m_s2, m_prev;

    always @(posedge clk) begin : ref_model
        logic [31:0] nxt;
        logic wr, r, f, ev, clr;
        wr = bus_sel && bus_enable && bus_write;
        if (!rst_n) begin
            m_mode = 0; m_dir = 0; m_out = 0; m_pol = 0; m_edge = 0; m_both = 0;
            m_en = 0; m_pend = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
        end else begin
            for (int i = 0; i < 32; i++) begin
                r   = m_s2[i] && !m_prev[i];
                f   = !m_s2[i] && m_prev[i];
                ev  = m_both[i] ? (r || f) : (m_pol[i] ? f : r);
                clr = wr && bus_addr == A_PEND && bus_wdata[i];
                if (!m_mode[i])      nxt[i] = 1'b0;
                else if (!m_edge[i]) nxt[i] = m_s2[i] ^ m_pol[i];
                else                 nxt[i] = (m_pend[i] && !clr) || ev;
            end
            if (wr) begin
                case (bus_addr)
                    A_MODE:   m_mode = bus_wdata;
                    A_DIR:    m_dir  = bus_wdata;
                    A_OUT:    m_out  = bus_wdata;
                    A_POL:    m_pol  = bus_wdata;
                    A_EDGE:   m_edge = bus_wdata;
                    A_BOTH:   m_both = bus_wdata;
                    A_MASK:   m_en   = m_en & ~bus_wdata;
                    A_UNMASK: m_en   = m_en | bus_wdata;
                    default:  ;
                endcase
            end
            m_pend = nxt;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pad_in;
        end
    end

    function automatic logic [31:0] mread(logic [5:0] a);
        logic [31:0] oe;
        oe = ~m_mode & m_dir;
        case (a)
            A_MODE: return m_mode;
            A_DIR:  return m_dir;
            A_OUT:  return m_out;
            A_PIN:  return (oe & m_out) | (~oe & m_s2);
            A_POL:  return m_pol;
            A_EDGE: return m_edge;
            A_BOTH: return m_both;
            A_PEND: return m_pend;
            A_MASK: return m_en;
            A_SYNC: return m_s2;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    // per-cycle comparison of the output pins (R2, R8)
    always @(negedge clk) begin
        if (!done) begin
            chk("R8 irq_out", {31'b0, irq_out}, {31'b0, |(m_pend & m_en)});
            chk("R2 pad_oe", pad_oe, ~m_mode & m_dir);
            chk("R2 pad_out", pad_out, m_out);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !done) begin
            done = 1'b1;
            misses++;
            $display("FAIL watchdog expired actual=%0d expected<60000", cyc);
            summary();
            $finish;
        end
    end

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(posedge clk) #1;
        bus_sel = 1; bus_enable = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk) #1;
        bus_write = 0; bus_sel = 0; bus_enable = 0;
    endtask

    task automatic rd(logic [5:0] a, string tag);
        @(posedge clk) #1;
        bus_sel = 1; bus_enable = 1; bus_write = 0; bus_addr = a;
        @(negedge clk);
        chk(tag, bus_rdata, mread(a));
    endtask

    task automatic pad(logic [31:0] v);
        @(posedge clk) #1;
        pad_in = v;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        idle(3);
        @(posedge clk) #1 rst_n = 1;
        // R1 reset state
        rd(A_MODE, "R1 mode");  rd(A_DIR, "R1 dir");  rd(A_OUT, "R1 out");
        rd(A_PEND, "R1 pend");  rd(A_MASK, "R1 enable");
        chk("R1 irq low", {31'b0, irq_out}, 32'h0);

        // R2 general output and pin readback
        wr(A_DIR, 32'h0000_00FF);
        wr(A_OUT, 32'h0000_00A5);
        pad(32'hFFFF_0F0F);
        idle(3);
        rd(A_PIN, "R2 pin data mixed");
        chk("R2 pin data literal", bus_rdata, 32'hFFFF_0FA5);

        // R3 synchroniser latency
        pad(32'h1234_5678);
        rd(A_SYNC, "R3 sync one edge");
        rd(A_SYNC, "R3 sync two edges");
        chk("R3 sync literal", bus_rdata, 32'h1234_5678);
        pad(32'h0);
        idle(3);

        // interrupt configuration: pins 8..14
        wr(A_POL,  32'h0000_6200);
        wr(A_EDGE, 32'h0000_7000);
        wr(A_BOTH, 32'h0000_4000);
        wr(A_MODE, 32'h0000_7F00);
        wr(A_UNMASK, 32'h0000_7F00);
        idle(2);
        // R4 level: pin 9 active low is already active, pin 8 not
        rd(A_PEND, "R4 level active low");
        chk("R4 pin9 pending", bus_rdata & 32'h300, 32'h200);
        wr(A_PEND, 32'h0000_0200);
        rd(A_PEND, "R4 clear ignored while active");
        pad(32'h0000_0300);
        idle(3);
        rd(A_PEND, "R4 level swap");
        chk("R4 pin8 pending", bus_rdata & 32'h300, 32'h100);

        // R5 single edges: pin 12 rising, pin 13 falling
        pad(32'h0000_1300);
        idle(4);
        rd(A_PEND, "R5 rise seen");
        chk("R5 pin12 set, pin13 clear", bus_rdata & 32'h3000, 32'h1000);
        pad(32'h0000_2300);
        idle(4);
        rd(A_PEND, "R5 sticky and falling");
        pad(32'h0000_0300);
        idle(4);
        rd(A_PEND, "R5 falling pin13");
        chk("R5 pin13 set", bus_rdata & 32'h2000, 32'h2000);

        // R7 clear with zeros then ones
        wr(A_PEND, 32'h0);
        rd(A_PEND, "R7 zero write no effect");
        wr(A_PEND, 32'h0000_3000);
        rd(A_PEND, "R7 ones clear");
        chk("R7 pins12,13 cleared", bus_rdata & 32'h3000, 32'h0);

        // R6 both edges on pin 14 with polarity set
        pad(32'h0000_4300);
        idle(4);
        rd(A_PEND, "R6 rise with pol=1");
        wr(A_PEND, 32'h0000_4000);
        pad(32'h0000_0300);
        idle(4);
        rd(A_PEND, "R6 fall");
        chk("R6 pin14 set", bus_rdata & 32'h4000, 32'h4000);
        wr(A_PEND, 32'h0000_4000);

        // R9 clear coinciding with the detecting edge (offset sweep)
        for (int d = 0; d < 4; d++) begin
            pad(32'h0000_1300);
            idle(d);
            wr(A_PEND, 32'h0000_1000);
            idle(3);
            rd(A_PEND, "R9 edge vs clear");
            pad(32'h0000_0300);
            wr(A_PEND, 32'h0000_1000);
            idle(3);
        end

        // R8 masking
        wr(A_MASK, 32'h0000_7F00);
        rd(A_MASK, "R8 masked all");
        chk("R8 irq masked", {31'b0, irq_out}, 32'h0);
        wr(A_UNMASK, 32'h0);
        rd(A_MASK, "R8 zero unmask no effect");
        wr(A_UNMASK, 32'h0000_0100);
        rd(A_UNMASK, "R8 unmask reads zero");
        rd(A_MASK, "R8 one pin enabled");

        // R10 leaving interrupt mode drops pending
        wr(A_MODE, 32'h0);
        idle(1);
        rd(A_PEND, "R10 general mode no pending");
        chk("R10 pending zero", bus_rdata, 32'h0);

        // mixed random traffic, model compares every cycle
        for (int n = 0; n < 600; n++) begin
            int op;
            op = $urandom_range(0, 5);
            case (op)
                0, 1: pad($urandom);
                2: wr(6'($urandom_range(0, 9) * 4), $urandom);
                3: wr(A_PEND, $urandom);
                default: rd(6'($urandom_range(0, 11) * 4), "R2 R4 R5 R6 random read");
            endcase
        end

        idle(2);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule